// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block collects the data bytes of one write transaction for a serial EEPROM before any of them reach the storage array. The protocol engine first loads a 12-bit word address; its upper seven bits select a 32-byte page and its lower five bits select the first slot to fill. Each byte strobe then stores one byte at the current slot and moves the in-page pointer forward. The pointer wraps inside the page, so the page never changes during a transaction.

When the protocol engine requests a commit, the block rewrites the entire page through its array port in ascending slot order. Slots that received a byte are written with the new data. All other slots are read from the array first and written back unchanged, so the whole page goes through one program cycle. An abort drops all buffered data without touching the array. After a transaction the pointer holds the address that follows the last byte written, which serves as the next current address.

Top module: `eeprom_pgbuf`

## Requirements
- R1: After reset, `busy_o` is 0, `ptr_o` is 0 and neither `arr_rd_o` nor `arr_wr_o` is asserted.
- R2: A `load_i` strobe while idle sets `ptr_o` to `load_addr_i` on the next cycle and discards any bytes buffered before it.
- R3: Each accepted byte is stored at slot `ptr_o[4:0]`. In the next cycle `ptr_o[4:0]` has increased by one and `ptr_o[11:5]` is unchanged.
- R4: The slot after 31 is slot 0 of the same page. When more than 32 bytes arrive, a later byte replaces the earlier byte in the same slot.
- R5: A commit writes each of the 32 addresses `{ptr_o[11:5], s}` exactly once, for s ascending from 0 to 31.
- R6: At commit, a slot that received a byte is written with the newest byte for that slot. Every other slot is written with the value the array held at that address before the commit.
- R7: An array read is issued only for a slot without new data, one cycle before that slot's write. `busy_o` stays high for 32 cycles plus one cycle per unwritten slot.
- R8: The array port is inactive (no read, no write) whenever `busy_o` is low.
- R9: `abort_i` while idle discards the buffered bytes without any array access. A commit with no byte buffered causes no array access and leaves `busy_o` low.
- R10: When `abort_i` and `commit_i` are high in the same cycle, the abort wins and no commit starts.
- R11: While `busy_o` is high, `load_i`, `byte_vld_i`, `commit_i` and `abort_i` have no effect. `ptr_o` stays stable and no byte is stored.
- R12: After a commit, `ptr_o` is the address that follows the last byte written. The buffer is then empty, so a second commit does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load the word address and start a new transaction |
| load_addr_i | input | 12 | Word address to load |
| byte_vld_i | input | 1 | Byte strobe |
| byte_data_i | input | 8 | Byte to buffer |
| commit_i | input | 1 | Write the buffered page to the array |
| abort_i | input | 1 | Discard the buffered bytes |
| busy_o | output | 1 | Page rewrite in progress |
| ptr_o | output | 12 | Current word address pointer |
| arr_addr_o | output | 12 | Array address |
| arr_rd_o | output | 1 | Array read strobe; data is returned in the next cycle |
| arr_rdata_i | input | 8 | Array read data |
| arr_wr_o | output | 1 | Array write strobe |
| arr_wdata_o | output | 8 | Array write data |

## Verification
On every cycle the assertions check the following rules. The array port stays quiet while idle. Each read is followed by a write to the same address, and reads are issued only for unwritten slots. Writes advance one slot at a time. A byte step changes only the low five pointer bits. The pointer is frozen during a rewrite, a finished rewrite empties the valid mask, and an abort never starts one. Only the bench scenarios can show what lands in the array: the merged page contents after wrap and overflow, that aborted data never reaches the array, and the exact rewrite length. They also show that strobes arriving during a rewrite leave no trace afterwards.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pgbuf_ptr.sv
module pgbuf_ptr #(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;

  // Only the in-page offset advances; the page bits are held.
  always_comb begin
    ptr_en = ld_i | step_i;
    ptr_d  = ptr_q;
    if (ld_i)
      ptr_d = ld_val_i;
    else if (step_i)
      ptr_d = {ptr_q[ADDR_W-1:OFS_W], ptr_q[OFS_W-1:0] + 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int OFS_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [OFS_W-1:0]        wr_slot_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [OFS_W-1:0]        rd_slot_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [(1<<OFS_W)-1:0]   valid_o
);
  localparam int SLOTS = 1 << OFS_W;

  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  valid_q, valid_d;

  // Data slots carry no reset; the valid mask qualifies them.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_i && (wr_slot_i == OFS_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) data_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (clr_i)
      valid_d = '0;
    else if (wr_i)
      valid_d[wr_slot_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                valid_q <= '0;
    else if (clr_i || wr_i)    valid_q <= valid_d;
  end

  assign rd_data_o = data_q[rd_slot_i];
  assign valid_o   = valid_q;

  AST_WR_MARKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i) |=> valid_q[$past(wr_slot_i)]); // R3
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [ADDR_W-OFS_W-1:0] page_i,
  input  logic [(1<<OFS_W)-1:0]   valid_i,
  input  logic [DATA_W-1:0]       buf_data_i,
  input  logic [DATA_W-1:0]       arr_rdata_i,
  output logic [OFS_W-1:0]        slot_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [ADDR_W-1:0]       arr_addr_o,
  output logic                    arr_rd_o,
  output logic                    arr_wr_o,
  output logic [DATA_W-1:0]       arr_wdata_o
);
  seq_state_e       state_q, state_d;
  logic [OFS_W-1:0] slot_q, slot_d;
  logic             last_slot;

  assign last_slot = (slot_q == '1);

  // Next state: a slot with new data is written at once, any other
  // slot is read first so its old value can be written back.
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    done_o  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (start_i) begin
        slot_d  = '0;
        state_d = valid_i[0] ? SEQ_WR : SEQ_RD;
      end
      SEQ_RD: state_d = SEQ_WR;
      SEQ_WR: begin
        if (last_slot) begin
          state_d = SEQ_IDLE;
          done_o  = 1'b1;
        end else begin
          slot_d  = slot_q + 1'b1;
          state_d = valid_i[slot_q + 1'b1] ? SEQ_WR : SEQ_RD;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  assign slot_o      = slot_q;
  assign busy_o      = (state_q != SEQ_IDLE);
  assign arr_addr_o  = {page_i, slot_q};
  assign arr_rd_o    = (state_q == SEQ_RD);
  assign arr_wr_o    = (state_q == SEQ_WR);
  assign arr_wdata_o = valid_i[slot_q] ? buf_data_i : arr_rdata_i;

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_o |=> (arr_wr_o && arr_addr_o == $past(arr_addr_o))); // R7
  AST_RD_ONLY_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_o |-> !valid_i[slot_o]); // R7
  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_o && !last_slot) |=> ((arr_rd_o || arr_wr_o) &&
      arr_addr_o[OFS_W-1:0] == OFS_W'($past(arr_addr_o[OFS_W-1:0]) + 1'b1))); // R5
endmodule

// File: rtl/eeprom_pgbuf.sv
module eeprom_pgbuf #(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic              arr_rd_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              arr_wr_o,
  output logic [DATA_W-1:0] arr_wdata_o
);
  localparam int SLOTS  = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              busy, done;
  logic              ld_acc, byte_acc, abort_acc, start, clr;
  logic [SLOTS-1:0]  valid;
  logic [OFS_W-1:0]  seq_slot;
  logic [DATA_W-1:0] buf_rd;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE_W-1:0] page;

  // Strobes are accepted only while idle; abort beats commit.
  always_comb begin
    ld_acc    = load_i & ~busy;
    abort_acc = abort_i & ~busy;
    byte_acc  = byte_vld_i & ~busy & ~load_i & ~abort_i & ~commit_i;
    start     = commit_i & ~busy & ~abort_i & ~load_i & (|valid);
    clr       = ld_acc | abort_acc | done;
  end

  assign page = ptr[ADDR_W-1:OFS_W];

  pgbuf_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n),
    .ld_i(ld_acc), .ld_val_i(load_addr_i), .step_i(byte_acc),
    .ptr_o(ptr)
  );

  pgbuf_store #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .clr_i(clr), .wr_i(byte_acc),
    .wr_slot_i(ptr[OFS_W-1:0]), .wr_data_i(byte_data_i),
    .rd_slot_i(seq_slot), .rd_data_o(buf_rd), .valid_o(valid)
  );

  pgbuf_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .start_i(start), .page_i(page), .valid_i(valid),
    .buf_data_i(buf_rd), .arr_rdata_i(arr_rdata_i),
    .slot_o(seq_slot), .busy_o(busy), .done_o(done),
    .arr_addr_o(arr_addr_o), .arr_rd_o(arr_rd_o),
    .arr_wr_o(arr_wr_o), .arr_wdata_o(arr_wdata_o)
  );

  assign busy_o = busy;
  assign ptr_o  = ptr;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (!arr_rd_o && !arr_wr_o)); // R8
  AST_STEP_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_acc |=> (ptr[ADDR_W-1:OFS_W] == $past(ptr[ADDR_W-1:OFS_W]) &&
      ptr[OFS_W-1:0] == OFS_W'($past(ptr[OFS_W-1:0]) + 1'b1))); // R3
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> $stable(ptr)); // R11
  AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> (valid == '0)); // R12
  AST_ABORT_NO_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (abort_i && !busy) |=> !busy); // R10
endmodule

// File: tb/eeprom_pgbuf_tb.sv
`timescale 1ns/1ps
module eeprom_pgbuf_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load, byte_vld, commit, abort;
  logic [11:0] load_addr;
  logic [7:0]  byte_data;
  logic        busy, arr_rd, arr_wr;
  logic [11:0] ptr, arr_addr;
  logic [7:0]  arr_rdata, arr_wdata;

  always #2 clk = ~clk;

  eeprom_pgbuf u_dut (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .load_addr_i(load_addr),
    .byte_vld_i(byte_vld), .byte_data_i(byte_data),
    .commit_i(commit), .abort_i(abort),
    .busy_o(busy), .ptr_o(ptr),
    .arr_addr_o(arr_addr), .arr_rd_o(arr_rd), .arr_rdata_i(arr_rdata),
    .arr_wr_o(arr_wr), .arr_wdata_o(arr_wdata)
  );

  // Array model: read data returned one cycle after the strobe.
  logic [7:0] mem [4096];
  always @(posedge clk) begin
    if (arr_rd) arr_rdata <= mem[arr_addr];
    if (arr_wr) mem[arr_addr] <= arr_wdata;
  end

  // Reference model of the buffer.
  logic [11:0] mptr;
  logic [7:0]  mbuf [32];
  logic [31:0] mval;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int exp_a[$], exp_d[$];
  int ea, ed;
  bit fin = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every array write.
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_rd) rd_cnt++;
      if (arr_wr) begin
        wr_cnt++;
        if (exp_a.size() == 0) begin
          chk(1'b0, "R8", "unexpected array write", arr_addr, 0);
        end else begin
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(arr_addr == ea, "R5", "write address", arr_addr, ea);
          chk(arr_wdata == ed, "R6", "write data", arr_wdata, ed);
        end
      end
    end
  end

  task automatic t_load(input logic [11:0] a);
    load = 1'b1; load_addr = a;
    @(negedge clk);
    load = 1'b0;
    mptr = a; mval = '0;
  endtask

  task automatic t_byte(input logic [7:0] d);
    byte_vld = 1'b1; byte_data = d;
    mbuf[mptr[4:0]] = d;
    mval[mptr[4:0]] = 1'b1;
    mptr[4:0] = mptr[4:0] + 5'd1;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  // Driver side of the scoreboard: push the merged page image.
  task automatic t_expect(output int inv);
    logic [11:0] a;
    inv = 0;
    if (mval != 0) begin
      for (int s = 0; s < 32; s++) begin
        a = {mptr[11:5], 5'(s)};
        exp_a.push_back(int'(a));
        if (mval[s]) exp_d.push_back(int'(mbuf[s]));
        else begin
          exp_d.push_back(int'(mem[a]));
          inv++;
        end
      end
    end
  endtask

  task automatic t_finish_commit(input int inv, input int rd0, input int cyc0);
    int cyc, want;
    cyc = cyc0;
    while (busy && cyc < 200) begin
      cyc++;
      @(negedge clk);
    end
    want = (mval != 0) ? 32 + inv : 0;
    chk(cyc == want, "R7", "busy cycles", cyc, want);
    chk(rd_cnt - rd0 == inv, "R7", "array reads", rd_cnt - rd0, inv);
    chk(exp_a.size() == 0, "R5", "writes still pending", exp_a.size(), 0);
    chk(ptr == mptr, "R12", "pointer after commit", ptr, mptr);
    mval = '0;
  endtask

  task automatic t_commit();
    int inv, rd0;
    t_expect(inv);
    rd0 = rd_cnt;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    t_finish_commit(inv, rd0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
    rst_n = 1'b0; load = 0; byte_vld = 0; commit = 0; abort = 0;
    load_addr = '0; byte_data = '0; mptr = '0; mval = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(ptr == 12'h000, "R1", "pointer after reset", ptr, 0);
    chk(!arr_rd && !arr_wr, "R1", "array strobes after reset", {arr_rd, arr_wr}, 0);

    // R2 load, R3 stepping, partial page commit (R5 R6 R7)
    t_load(12'h123);
    chk(ptr == 12'h123, "R2", "pointer after load", ptr, 12'h123);
    t_byte(8'hA1); t_byte(8'hB2); t_byte(8'hC3);
    chk(ptr == 12'h126, "R3", "pointer after three bytes", ptr, 12'h126);
    t_commit();

    // R12 second commit with empty buffer does nothing
    begin
      int w0;
      w0 = wr_cnt;
      t_commit();
      chk(wr_cnt == w0, "R12", "writes on empty commit", wr_cnt - w0, 0);
    end

    // R4 wrap at page end stays in the page
    t_load(12'h7FD);
    for (int i = 0; i < 5; i++) t_byte(8'(8'h30 + i));
    chk(ptr == 12'h7E2, "R4", "pointer after wrap", ptr, 12'h7E2);
    t_commit();

    // R4 overflow: 40 bytes, later bytes replace earlier ones, no reads
    t_load(12'h400);
    for (int i = 0; i < 40; i++) t_byte(8'(8'h40 + i));
    chk(ptr == 12'h408, "R4", "pointer after overflow", ptr, 12'h408);
    t_commit();

    // R4 top of array: 0xFFF wraps to 0xFE0
    t_load(12'hFFF);
    t_byte(8'h5A);
    chk(ptr == 12'hFE0, "R4", "pointer wrap at last address", ptr, 12'hFE0);
    t_byte(8'h6B);
    t_commit();

    // R2 reload discards earlier bytes
    t_load(12'h200);
    t_byte(8'h11);
    t_load(12'h260);
    t_byte(8'h22);
    t_commit();

    // R9 abort discards buffered data, no array access
    begin
      int w0, r0;
      t_load(12'h900);
      t_byte(8'h77); t_byte(8'h88);
      w0 = wr_cnt; r0 = rd_cnt;
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      mval = '0;
      repeat (3) @(negedge clk);
      chk(wr_cnt == w0 && rd_cnt == r0, "R9", "array access after abort",
          wr_cnt - w0 + rd_cnt - r0, 0);
      t_commit();
      t_byte(8'h99);
      t_commit();
    end

    // R10 abort and commit together: abort wins
    begin
      int w0;
      t_load(12'hA40);
      t_byte(8'h12);
      w0 = wr_cnt;
      abort = 1'b1; commit = 1'b1;
      @(negedge clk);
      abort = 1'b0; commit = 1'b0;
      mval = '0;
      chk(busy == 1'b0, "R10", "busy after abort with commit", busy, 0);
      repeat (3) @(negedge clk);
      chk(wr_cnt == w0, "R10", "writes after abort with commit", wr_cnt - w0, 0);
    end

    // R11 strobes during the rewrite are ignored
    begin
      int inv, rd0;
      t_load(12'h345);
      t_byte(8'hD1); t_byte(8'hD2);
      t_expect(inv);
      rd0 = rd_cnt;
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      load = 1'b1; load_addr = 12'hABC; byte_vld = 1'b1; byte_data = 8'hEE; abort = 1'b1;
      @(negedge clk);
      load = 1'b0; byte_vld = 1'b0; abort = 1'b0;
      t_finish_commit(inv, rd0, 1);
      chk(ptr == 12'h347, "R11", "pointer after strobes while busy", ptr, 12'h347);
      t_commit();
    end

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule